// File: doc/BRIEF.md
# Configurable PLD Macrocell

This block is one macrocell of a programmable-logic array. A wide AND plane forms product terms from the true and complement forms of the array inputs. Eight logic terms are ORed together, and an XOR stage applies a programmable inversion. The result either goes straight out (bypass) or feeds a register. That register can be set up as a D, T, JK or SR flip-flop. Three more product terms serve the cell itself: a register clear, an output enable and an array clock.

All configuration is static and arrives on plain input vectors: the AND fuse map, the register kind, the bypass bit, the inversion bit and the mode bit. The feedback output carries the macrocell value to the surrounding array, which can route it back onto `arr_i`. The pin output drives that value, or high impedance. The block runs on one system clock with a synchronous reset. The selected array clock is detected as a low-to-high change of its product term between two consecutive system clock cycles.

Top module: `pld_macrocell`

## Requirements
- R1: Fuse bit 2i of a term selects array input i in true form, and bit 2i+1 selects it in complement form. The mask of term p sits at bits [p*32 +: 32] of `fuse_i`. Terms 0..7 are logic terms, term 8 is the clear, term 9 the output enable and term 10 the array clock. A term is the AND of its selected literals. A term with no fuse set is 1, and a term that selects both forms of one input is 0.
- R2: The combinational value is the OR of terms 0..7 XOR `invert_i` when `reg_kind_i` is 0 (D) or 1 (T). It is the OR of terms 0..6 XOR `invert_i` when `reg_kind_i` is 2 (JK) or 3 (SR).
- R3: With kind D, on an update the register takes the combinational value.
- R4: With kind T, on an update the register toggles when the combinational value is 1 and holds when it is 0.
- R5: With kind JK, the combinational value is J and term 7 is K. J only sets, K only resets, both toggle, and neither holds.
- R6: With kind SR, the combinational value is S and term 7 is R. S alone sets, R alone resets, and both or neither hold.
- R7: With `bypass_i` set, `fb_o` equals the combinational value in the same cycle. Otherwise `fb_o` is the register output.
- R8: When the clear term is 1 at a clock edge, the register becomes 0 at that edge in either mode, ahead of any update.
- R9: While `rst_i` is high the register goes to 0, and the array-clock history is set so that no edge is seen in the first cycle after reset.
- R10: In mode 0 (`mode_i`=0), `drive_o` equals the output-enable term, the register updates on every clock edge, and `pin_o` equals `fb_o` while driven and is 'z otherwise.
- R11: In mode 1, `drive_o` is always 1. The register updates only at an edge where the clock term is 1 and was 0 at the previous edge. A complement-form fuse therefore gives a falling-edge trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (global) clock |
| rst_i | input | 1 | Synchronous active-high reset |
| arr_i | input | 16 | Array inputs, feedback included by the surrounding array |
| fuse_i | input | 352 | AND fuse map, 11 terms of 32 bits |
| reg_kind_i | input | 2 | Register kind: 0 D, 1 T, 2 JK, 3 SR |
| bypass_i | input | 1 | Bypass the register |
| invert_i | input | 1 | Invert the sum of products |
| mode_i | input | 1 | 0: term output enable, global clock; 1: always driven, term clock |
| fb_o | output | 1 | Feedback value to the array |
| drive_o | output | 1 | Pin output enable |
| pin_o | output | 1 | Tri-state pin output |

## Verification
The bench applies random array inputs to sparse random fuse masks, so that product terms fire only some of the time. It does this for each register kind, with the register bypassed and not bypassed and with inversion on and off. Directed fuse maps separate the empty-term and contradictory-term cases from ordinary ANDing. Single-literal masks on term 7 and the logic terms make J/K and S/R collide often, which exposes the toggle and hold corners. In mode 1 the clock term is built from one input in true form and then in complement form, to tell rising-edge triggering apart from falling-edge triggering. The clear term is tried while updates are also pending, which shows whether clear takes priority.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    KIND_D  = 2'd0,
    KIND_T  = 2'd1,
    KIND_JK = 2'd2,
    KIND_SR = 2'd3
  } ff_kind_e;
endpackage

// File: rtl/mc_and_plane.sv
module mc_and_plane #(
  parameter int N_IN = 16,
  parameter int N_PT = 11,
  localparam int FW = 2 * N_IN
) (
  input  logic [N_IN-1:0]      arr_i,
  input  logic [N_PT*FW-1:0]   fuse_i,
  output logic [N_PT-1:0]      pt_o
);
  logic [FW-1:0] lits;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = arr_i[i];
    assign lits[2*i+1] = ~arr_i[i];
  end

  for (genvar p = 0; p < N_PT; p++) begin : g_term
    assign pt_o[p] = &(~fuse_i[p*FW +: FW] | lits);
  end
endmodule

// File: rtl/mc_sop.sv
module mc_sop
  import mc_pkg::*;
#(
  parameter int N_LOGIC = 8
) (
  input  logic [N_LOGIC-1:0] term_i,
  input  ff_kind_e           kind_i,
  input  logic               invert_i,
  output logic               x_o,
  output logic               kr_o
);
  logic split;
  logic sum_all;
  logic sum_low;

  assign split   = (kind_i == KIND_JK) || (kind_i == KIND_SR);
  assign sum_all = |term_i;
  assign sum_low = |term_i[N_LOGIC-2:0];
  assign x_o     = (split ? sum_low : sum_all) ^ invert_i;
  assign kr_o    = term_i[N_LOGIC-1];
endmodule

// File: rtl/mc_ff.sv
module mc_ff
  import mc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  ff_kind_e kind_i,
  input  logic     mode_i,
  input  logic     clk_pt_i,
  input  logic     clr_pt_i,
  input  logic     x_i,
  input  logic     kr_i,
  output logic     q_o
);
  logic q;
  logic clk_prev;
  logic tick;
  logic nxt;

  assign tick = mode_i ? (clk_pt_i & ~clk_prev) : 1'b1;

  always_comb begin
    nxt = q;
    unique case (kind_i)
      KIND_D:  nxt = x_i;
      KIND_T:  nxt = q ^ x_i;
      KIND_JK: begin
        if (x_i && kr_i)  nxt = ~q;
        else if (x_i)     nxt = 1'b1;
        else if (kr_i)    nxt = 1'b0;
      end
      KIND_SR: begin
        if (x_i && !kr_i)      nxt = 1'b1;
        else if (kr_i && !x_i) nxt = 1'b0;
      end
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q        <= 1'b0;
      clk_prev <= 1'b1;
    end else begin
      clk_prev <= clk_pt_i;
      if (clr_pt_i)  q <= 1'b0;
      else if (tick) q <= nxt;
    end
  end

  assign q_o = q;

  p_clear_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_pt_i |=> (q_o == 1'b0));

  p_reset_r9: assert property (@(posedge clk_i)
    rst_i |=> (q_o == 1'b0));

  p_dff_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_i == KIND_D && !mode_i && !clr_pt_i) |=> (q_o == $past(x_i)));

  p_sr_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_i == KIND_SR && x_i && kr_i && !clr_pt_i) |=> $stable(q_o));

  p_no_edge_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i && !clk_pt_i && !clr_pt_i) |=> $stable(q_o));
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import mc_pkg::*;
#(
  parameter int N_IN    = 16,
  parameter int N_LOGIC = 8,
  localparam int FW     = 2 * N_IN,
  localparam int N_PT   = N_LOGIC + 3,
  localparam int PT_CLR = N_LOGIC,
  localparam int PT_OE  = N_LOGIC + 1,
  localparam int PT_CLK = N_LOGIC + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [N_IN-1:0]      arr_i,
  input  logic [N_PT*FW-1:0]   fuse_i,
  input  logic [1:0]           reg_kind_i,
  input  logic                 bypass_i,
  input  logic                 invert_i,
  input  logic                 mode_i,
  output logic                 fb_o,
  output logic                 drive_o,
  output logic                 pin_o
);
  logic [N_PT-1:0] pt;
  ff_kind_e        kind;
  logic            x;
  logic            kr;
  logic            q;

  assign kind = ff_kind_e'(reg_kind_i);

  mc_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_plane (
    .arr_i  (arr_i),
    .fuse_i (fuse_i),
    .pt_o   (pt)
  );

  mc_sop #(.N_LOGIC(N_LOGIC)) u_sop (
    .term_i   (pt[N_LOGIC-1:0]),
    .kind_i   (kind),
    .invert_i (invert_i),
    .x_o      (x),
    .kr_o     (kr)
  );

  mc_ff u_ff (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .kind_i   (kind),
    .mode_i   (mode_i),
    .clk_pt_i (pt[PT_CLK]),
    .clr_pt_i (pt[PT_CLR]),
    .x_i      (x),
    .kr_i     (kr),
    .q_o      (q)
  );

  assign fb_o    = bypass_i ? x : q;
  assign drive_o = mode_i | pt[PT_OE];
  assign pin_o   = drive_o ? fb_o : 1'bz;

  p_mode1_drive_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_i |-> drive_o);

  p_empty_term_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (fuse_i[0 +: FW] == '0) |-> pt[0]);

  p_bypass_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!bypass_i && !mode_i && kind == KIND_D && !pt[PT_CLR]) |=> (fb_o == $past(x)));
endmodule

// File: tb/pld_macrocell_tb_top.sv
`timescale 1ns/1ps
module pld_macrocell_tb_top;
  logic         clk = 1'b0;
  logic         rst_i;
  logic [15:0]  arr_i;
  logic [351:0] fuse;
  logic [1:0]   kind;
  logic         bypass, invert, mode;
  logic         fb_o, drive_o, pin_o;

  int n_cmp = 0;
  int n_bad = 0;
  int mq = 0;
  int mprev = 1;

  always #4 clk = ~clk;

  pld_macrocell dut_i (
    .clk_i(clk), .rst_i(rst_i), .arr_i(arr_i), .fuse_i(fuse),
    .reg_kind_i(kind), .bypass_i(bypass), .invert_i(invert), .mode_i(mode),
    .fb_o(fb_o), .drive_o(drive_o), .pin_o(pin_o)
  );

  function automatic int term(int p);
    for (int i = 0; i < 16; i++) begin
      if (fuse[p*32 + 2*i] && !arr_i[i]) return 0;
      if (fuse[p*32 + 2*i + 1] && arr_i[i]) return 0;
    end
    return 1;
  endfunction

  function automatic logic [31:0] sparse(int k);
    logic [31:0] m = '0;
    for (int j = 0; j < k; j++) m[$urandom_range(31, 0)] = 1'b1;
    return m;
  endfunction

  task automatic chk(string tag, logic act, int exp);
    n_cmp++;
    if (act !== exp[0]) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic [15:0] a);
    int sum, x, kr, fbx, drv, nxt, clkv;
    arr_i = a;
    #1;
    sum = 0;
    for (int p = 0; p < ((kind >= 2) ? 7 : 8); p++) sum |= term(p);
    x = sum ^ int'(invert);
    kr = term(7);
    fbx = bypass ? x : mq;
    drv = (mode || term(9)) ? 1 : 0;
    chk(tag, fb_o, fbx);
    chk(tag, drive_o, drv);
    if (drv != 0) chk(tag, pin_o, fbx);
    nxt = mq;
    case (kind)
      2'd0: nxt = x;
      2'd1: nxt = mq ^ x;
      2'd2: nxt = (x && kr) ? 1 - mq : x ? 1 : kr ? 0 : mq;
      default: nxt = (x && !kr) ? 1 : (kr && !x) ? 0 : mq;
    endcase
    if (rst_i) begin
      mq = 0; mprev = 1;
    end else begin
      clkv = term(10);
      if (term(8) != 0) mq = 0;
      else if (!mode || (clkv != 0 && mprev == 0)) mq = nxt;
      mprev = clkv;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(string tag, int n);
    for (int c = 0; c < n; c++) step(tag, 16'($urandom));
  endtask

  localparam logic [31:0] NEVER = 32'h3;

  task automatic cfg(logic [1:0] k, logic b, logic inv, logic m, int lits);
    kind = k; bypass = b; invert = inv; mode = m;
    for (int p = 0; p < 8; p++) fuse[p*32 +: 32] = sparse(lits);
    fuse[8*32 +: 32]  = NEVER;
    fuse[9*32 +: 32]  = sparse(1);
    fuse[10*32 +: 32] = NEVER;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_i = 1'b1; arr_i = '0;
    cfg(2'd0, 1'b0, 1'b0, 1'b0, 3);
    @(negedge clk);
    // R9: reset holds register at zero
    for (int c = 0; c < 4; c++) step("R9", 16'($urandom));
    rst_i = 1'b0;
    // R1: empty term is 1, contradictory terms are 0
    cfg(2'd0, 1'b1, 1'b0, 1'b0, 3);
    for (int p = 0; p < 8; p++) fuse[p*32 +: 32] = NEVER;
    fuse[0 +: 32] = '0;
    run("R1", 20);
    for (int p = 0; p < 8; p++) fuse[p*32 +: 32] = 32'h0000_0030 | (32'h1 << p*2);
    fuse[0 +: 32] = NEVER;
    run("R1", 40);
    // R2 / R7: bypass sum with and without inversion
    cfg(2'd0, 1'b1, 1'b0, 1'b0, 2); run("R2", 200);
    cfg(2'd2, 1'b1, 1'b1, 1'b0, 2); run("R7", 200);
    // R3, R4, R5, R6: register kinds in mode 0
    cfg(2'd0, 1'b0, 1'b0, 1'b0, 3); run("R3", 200);
    cfg(2'd1, 1'b0, 1'b1, 1'b0, 3); run("R4", 200);
    cfg(2'd2, 1'b0, 1'b0, 1'b0, 2); fuse[7*32 +: 32] = sparse(1); run("R5", 300);
    cfg(2'd3, 1'b0, 1'b0, 1'b0, 2); fuse[7*32 +: 32] = sparse(1); run("R6", 300);
    // R8: clear term active now and then
    cfg(2'd1, 1'b0, 1'b1, 1'b0, 3); fuse[8*32 +: 32] = sparse(2); run("R8", 200);
    cfg(2'd0, 1'b0, 1'b1, 1'b1, 3); fuse[8*32 +: 32] = sparse(3);
    fuse[10*32 +: 32] = 32'h1 << 6; run("R8", 200);
    // R10: output-enable term in mode 0
    cfg(2'd0, 1'b0, 1'b0, 1'b0, 2); fuse[9*32 +: 32] = sparse(2); run("R10", 200);
    // R11: rising and falling array clock
    cfg(2'd0, 1'b0, 1'b0, 1'b1, 2); fuse[10*32 +: 32] = 32'h1 << 10; run("R11", 250);
    cfg(2'd1, 1'b0, 1'b1, 1'b1, 2); fuse[10*32 +: 32] = 32'h1 << 11; run("R11", 250);
    cfg(2'd3, 1'b0, 1'b0, 1'b1, 2); fuse[10*32 +: 32] = 32'h1 << 3; run("R11", 200);
    // R9: reset in mid-run clears register and edge history
    rst_i = 1'b1; run("R9", 3);
    rst_i = 1'b0; run("R9", 100);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule